// File: doc/BRIEF.md
# Explicit Register Rename Unit

This block sits in the decode stage and gives every result-producing instruction a physical register of its own. It looks up the two source operands through a speculative map from architectural to physical register numbers. When the instruction writes a result, it takes the oldest entry from a FIFO of free physical registers and records that register as the destination's newest mapping. It also reports the mapping the destination held before, so that the retirement logic can hand it back later. The block reads no register values. One instruction is renamed per cycle.

A second map holds only retired state. When a writer retires, its destination is recorded in the committed map and the physical register it displaced goes back to the free list. A flush discards all speculative state: the speculative map becomes a copy of the committed map. The free list is then rebuilt, in ascending order, from every physical register the committed map does not reference. Architectural register 0 is hard-wired to physical register 0 and is never renamed.

Top module: `rename_unit`

## Requirements
- R1: After reset, architectural register i maps to physical register i for every i in 0..31, and the free list holds physical registers 32 to 63 in ascending order.
- R2: In the same cycle, ren_psrc1_o and ren_psrc2_o give the speculative mapping of ren_src1_i and ren_src2_i. Source register 0 always yields physical register 0.
- R3: An accepted writer (ren_wr_i=1, ren_dst_i nonzero) gets the free-list head on ren_pdst_o. From the next cycle on, its destination maps to that register. The instruction's own sources see the mapping from before the write.
- R4: For an accepted writer, ren_pold_o gives the mapping its destination held just before the rename.
- R5: An accepted instruction with ren_wr_i=0 or ren_dst_i=0 allocates nothing. It drives 0 on ren_pdst_o and ren_pold_o and leaves the free list unchanged.
- R6: ren_ready_o is low while a writer is presented and the free list is empty. An instruction that does not write is still accepted in that state.
- R7: cmt_valid_i with cmt_arch_i nonzero sets the committed mapping of cmt_arch_i to cmt_phys_i and appends cmt_old_i to the tail of the free list.
- R8: An allocation and a reclaim in the same cycle both take effect.
- R9: While flush_i is high, ren_ready_o is low. After flush_i, the speculative map equals the committed map, including a commit presented in the same cycle. The free list then holds exactly the unreferenced physical registers, in ascending order.
- R10: Physical registers are handed out in first-in first-out order of their entry into the free list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ren_valid_i | input | 1 | Instruction presented for renaming |
| ren_wr_i | input | 1 | Instruction writes a result |
| ren_src1_i | input | 5 | First source architectural register |
| ren_src2_i | input | 5 | Second source architectural register |
| ren_dst_i | input | 5 | Destination architectural register |
| ren_ready_o | output | 1 | Instruction is accepted this cycle when valid |
| ren_psrc1_o | output | 6 | First source physical register |
| ren_psrc2_o | output | 6 | Second source physical register |
| ren_pdst_o | output | 6 | Newly allocated destination physical register |
| ren_pold_o | output | 6 | Previous mapping of the destination |
| cmt_valid_i | input | 1 | A writer retires this cycle |
| cmt_arch_i | input | 5 | Retiring writer's destination architectural register |
| cmt_phys_i | input | 6 | Retiring writer's physical register |
| cmt_old_i | input | 6 | Physical register displaced by the retiring writer |
| flush_i | input | 1 | Discard speculative state |

## Verification
Directed sequences come first. Back-to-back writers to one register separate the new mapping from the old one reported for reclaim, and a write to register 0 shows that it consumes nothing. Draining the free list without retirement exposes the stall, which only writers see. Retiring while renaming shows a reclaimed register reappearing after the older free entries. A flush issued alongside a commit separates a rebuild that uses the updated committed map from one that uses the stale map. A long random mix of sources, writers, retirements and flushes is then compared every cycle against a queue-based model of both maps and the free list.

// File: rtl/rename_pkg.sv
package rename_pkg;
  localparam int unsigned DEF_ARCH_REGS = 32;
  localparam int unsigned DEF_PHYS_REGS = 64;
endpackage

// File: rtl/rename_map_table.sv
module rename_map_table #(
  parameter int unsigned NUM_ARCH = rename_pkg::DEF_ARCH_REGS,
  parameter int unsigned NUM_PHYS = rename_pkg::DEF_PHYS_REGS,
  localparam int unsigned AW = $clog2(NUM_ARCH),
  localparam int unsigned PW = $clog2(NUM_PHYS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [AW-1:0]       rd1_arch_i,
  input  logic [AW-1:0]       rd2_arch_i,
  input  logic [AW-1:0]       rdd_arch_i,
  output logic [PW-1:0]       rd1_phys_o,
  output logic [PW-1:0]       rd2_phys_o,
  output logic [PW-1:0]       rdd_phys_o,
  input  logic                wr_en_i,
  input  logic [AW-1:0]       wr_arch_i,
  input  logic [PW-1:0]       wr_phys_i,
  input  logic                cmt_en_i,
  input  logic [AW-1:0]       cmt_arch_i,
  input  logic [PW-1:0]       cmt_phys_i,
  input  logic                flush_i,
  output logic [NUM_PHYS-1:0] used_o
);

  logic [PW-1:0] spec_q [NUM_ARCH];
  logic [PW-1:0] cmap_q [NUM_ARCH];
  logic [PW-1:0] cmap_d [NUM_ARCH];

  assign rd1_phys_o = (rd1_arch_i == '0) ? '0 : spec_q[rd1_arch_i];
  assign rd2_phys_o = (rd2_arch_i == '0) ? '0 : spec_q[rd2_arch_i];
  assign rdd_phys_o = (rdd_arch_i == '0) ? '0 : spec_q[rdd_arch_i];

  // committed map including this cycle's retirement; flush and rebuild see it
  always_comb begin
    for (int a = 0; a < NUM_ARCH; a++) cmap_d[a] = cmap_q[a];
    if (cmt_en_i && cmt_arch_i != '0) cmap_d[cmt_arch_i] = cmt_phys_i;
  end

  always_comb begin
    used_o = '0;
    for (int a = 0; a < NUM_ARCH; a++) used_o[cmap_d[a]] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int a = 0; a < NUM_ARCH; a++) begin
        spec_q[a] <= PW'(a);
        cmap_q[a] <= PW'(a);
      end
    end else begin
      for (int a = 0; a < NUM_ARCH; a++) cmap_q[a] <= cmap_d[a];
      if (flush_i) begin
        for (int a = 0; a < NUM_ARCH; a++) spec_q[a] <= cmap_d[a];
      end else if (wr_en_i && wr_arch_i != '0) begin
        spec_q[wr_arch_i] <= wr_phys_i;
      end
    end
  end

  assert_map_update_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !flush_i && wr_arch_i != '0) |=> spec_q[$past(wr_arch_i)] == $past(wr_phys_i));

  assert_flush_copy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && cmt_en_i && cmt_arch_i != '0) |=> spec_q[$past(cmt_arch_i)] == $past(cmt_phys_i));

  assert_zero_pinned_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spec_q[0] == '0 && cmap_q[0] == '0);

endmodule

// File: rtl/rename_free_list.sv
module rename_free_list #(
  parameter int unsigned NUM_ARCH = rename_pkg::DEF_ARCH_REGS,
  parameter int unsigned NUM_PHYS = rename_pkg::DEF_PHYS_REGS,
  localparam int unsigned PW = $clog2(NUM_PHYS),
  localparam int unsigned CW = $clog2(NUM_PHYS + 1),
  localparam int unsigned INIT_FREE = NUM_PHYS - NUM_ARCH
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                pop_i,
  input  logic                push_i,
  input  logic [PW-1:0]       push_id_i,
  input  logic                load_i,
  input  logic [NUM_PHYS-1:0] used_i,
  output logic [PW-1:0]       head_o,
  output logic                empty_o
);

  logic [PW-1:0] fifo_q [NUM_PHYS];
  logic [PW-1:0] rb_list [NUM_PHYS];
  logic [CW-1:0] rb_cnt;
  logic [PW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(NUM_PHYS - 1)) ? '0 : p + 1'b1;
  endfunction

  // ascending compaction of the unreferenced registers
  always_comb begin
    rb_cnt = '0;
    for (int p = 0; p < NUM_PHYS; p++) rb_list[p] = '0;
    for (int p = 0; p < NUM_PHYS; p++) begin
      if (!used_i[p]) begin
        rb_list[rb_cnt[PW-1:0]] = PW'(p);
        rb_cnt = rb_cnt + 1'b1;
      end
    end
  end

  assign head_o  = fifo_q[rd_q];
  assign empty_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_PHYS; i++)
        fifo_q[i] <= (i < INIT_FREE) ? PW'(i + NUM_ARCH) : '0;
      rd_q  <= '0;
      wr_q  <= PW'(INIT_FREE);
      cnt_q <= CW'(INIT_FREE);
    end else if (load_i) begin
      for (int i = 0; i < NUM_PHYS; i++) fifo_q[i] <= rb_list[i];
      rd_q  <= '0;
      wr_q  <= rb_cnt[PW-1:0];
      cnt_q <= rb_cnt;
    end else begin
      if (push_i) begin
        fifo_q[wr_q] <= push_id_i;
        wr_q         <= ptr_inc(wr_q);
      end
      if (pop_i) rd_q <= ptr_inc(rd_q);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !load_i) |-> cnt_q < CW'(NUM_PHYS));

  assert_no_underflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);

  assert_push_pop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && !load_i) |=> $stable(cnt_q));

  assert_rebuild_count_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == CW'(INIT_FREE));

endmodule

// File: rtl/rename_unit.sv
module rename_unit #(
  parameter int unsigned NUM_ARCH = rename_pkg::DEF_ARCH_REGS,
  parameter int unsigned NUM_PHYS = rename_pkg::DEF_PHYS_REGS,
  localparam int unsigned AW = $clog2(NUM_ARCH),
  localparam int unsigned PW = $clog2(NUM_PHYS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ren_valid_i,
  input  logic          ren_wr_i,
  input  logic [AW-1:0] ren_src1_i,
  input  logic [AW-1:0] ren_src2_i,
  input  logic [AW-1:0] ren_dst_i,
  output logic          ren_ready_o,
  output logic [PW-1:0] ren_psrc1_o,
  output logic [PW-1:0] ren_psrc2_o,
  output logic [PW-1:0] ren_pdst_o,
  output logic [PW-1:0] ren_pold_o,
  input  logic          cmt_valid_i,
  input  logic [AW-1:0] cmt_arch_i,
  input  logic [PW-1:0] cmt_phys_i,
  input  logic [PW-1:0] cmt_old_i,
  input  logic          flush_i
);

  logic                needs_alloc, fire, alloc, reclaim, fl_empty;
  logic [PW-1:0]       fl_head, old_map;
  logic [NUM_PHYS-1:0] used;

  assign needs_alloc = ren_wr_i && (ren_dst_i != '0);
  assign ren_ready_o = !flush_i && !(needs_alloc && fl_empty);
  assign fire        = ren_valid_i && ren_ready_o;
  assign alloc       = fire && needs_alloc;
  assign reclaim     = cmt_valid_i && (cmt_arch_i != '0);
  assign ren_pdst_o  = alloc ? fl_head : '0;
  assign ren_pold_o  = alloc ? old_map : '0;

  rename_map_table #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_map (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd1_arch_i (ren_src1_i),
    .rd2_arch_i (ren_src2_i),
    .rdd_arch_i (ren_dst_i),
    .rd1_phys_o (ren_psrc1_o),
    .rd2_phys_o (ren_psrc2_o),
    .rdd_phys_o (old_map),
    .wr_en_i    (alloc),
    .wr_arch_i  (ren_dst_i),
    .wr_phys_i  (fl_head),
    .cmt_en_i   (reclaim),
    .cmt_arch_i (cmt_arch_i),
    .cmt_phys_i (cmt_phys_i),
    .flush_i    (flush_i),
    .used_o     (used)
  );

  rename_free_list #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_free (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pop_i     (alloc),
    .push_i    (reclaim),
    .push_id_i (cmt_old_i),
    .load_i    (flush_i),
    .used_i    (used),
    .head_o    (fl_head),
    .empty_o   (fl_empty)
  );

  assert_src_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ren_src1_i == '0) |-> (ren_psrc1_o == '0));

  assert_flush_stall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> !ren_ready_o);

  assert_fresh_dst_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && needs_alloc) |-> (ren_pdst_o != '0 && ren_pdst_o != ren_pold_o));

  assert_dst_visible_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc && !flush_i) |=> ((ren_src1_i != $past(ren_dst_i)) || (ren_psrc1_o == $past(ren_pdst_o))));

  assert_no_alloc_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !ren_wr_i) |-> (ren_pdst_o == '0));

endmodule

// File: tb/sim_rename_unit.sv
`timescale 1ns/1ps
module sim_rename_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ren_valid = 1'b0, ren_wr = 1'b0, cmt_valid = 1'b0, flush = 1'b0;
  logic [4:0] src1 = '0, src2 = '0, dst = '0, cmt_arch = '0;
  logic [5:0] cmt_phys = '0, cmt_old = '0;
  logic ready;
  logic [5:0] psrc1, psrc2, pdst, pold;

  always #2 clk = ~clk;

  rename_unit u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .ren_valid_i(ren_valid), .ren_wr_i(ren_wr),
    .ren_src1_i(src1), .ren_src2_i(src2), .ren_dst_i(dst),
    .ren_ready_o(ready), .ren_psrc1_o(psrc1), .ren_psrc2_o(psrc2),
    .ren_pdst_o(pdst), .ren_pold_o(pold),
    .cmt_valid_i(cmt_valid), .cmt_arch_i(cmt_arch), .cmt_phys_i(cmt_phys),
    .cmt_old_i(cmt_old), .flush_i(flush)
  );

  int errors = 0, checks = 0, cycles = 0;
  bit done = 0;
  string ph = "R1";
  int smap [32];
  int cmap [32];
  int flq [$];
  int inf_arch [$], inf_phys [$], inf_old [$];

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s [%s] act=%0d exp=%0d", tag, ph, act, exp);
    end
  endtask

  task automatic rebuild();
    bit used [64];
    flq.delete();
    for (int p = 0; p < 64; p++) used[p] = 0;
    for (int a = 0; a < 32; a++) used[cmap[a]] = 1;
    for (int p = 0; p < 64; p++) if (!used[p]) flq.push_back(p);
  endtask

  task automatic step(bit v, bit w, int s1, int s2, int d, bit cv, bit fl);
    bit alloc, rdy, fire, cmt;
    int e_pdst, e_pold, c_a, c_p, c_o;
    @(negedge clk);
    ren_valid = v; ren_wr = w; src1 = 5'(s1); src2 = 5'(s2); dst = 5'(d); flush = fl;
    cmt = cv && inf_arch.size() > 0;
    c_a = cmt ? inf_arch[0] : 0; c_p = cmt ? inf_phys[0] : 0; c_o = cmt ? inf_old[0] : 0;
    cmt_valid = cmt; cmt_arch = 5'(c_a); cmt_phys = 6'(c_p); cmt_old = 6'(c_o);
    #1;
    alloc = w && d != 0;
    rdy = !fl && !(alloc && flq.size() == 0);
    fire = v && rdy;
    check("R6 ready", int'(ready), int'(rdy));
    e_pdst = 0; e_pold = 0;
    if (fire) begin
      check("R2 psrc1", int'(psrc1), s1 == 0 ? 0 : smap[s1]);
      check("R2 psrc2", int'(psrc2), s2 == 0 ? 0 : smap[s2]);
      if (alloc) begin
        e_pdst = flq[0]; e_pold = smap[d];
        check("R3 R10 pdst", int'(pdst), e_pdst);
        check("R4 pold", int'(pold), e_pold);
      end else begin
        check("R5 pdst", int'(pdst), 0);
        check("R5 pold", int'(pold), 0);
      end
    end
    @(posedge clk);
    cycles++;
    if (cmt) begin
      void'(inf_arch.pop_front()); void'(inf_phys.pop_front()); void'(inf_old.pop_front());
      cmap[c_a] = c_p;
    end
    if (fl) begin
      for (int a = 0; a < 32; a++) smap[a] = cmap[a];
      rebuild();
      inf_arch.delete(); inf_phys.delete(); inf_old.delete();
    end else begin
      if (fire && alloc) begin
        void'(flq.pop_front());
        smap[d] = e_pdst;
        inf_arch.push_back(d); inf_phys.push_back(e_pdst); inf_old.push_back(e_pold);
      end
      if (cmt) flq.push_back(c_o);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    for (int a = 0; a < 32; a++) begin smap[a] = a; cmap[a] = a; end
    for (int p = 32; p < 64; p++) flq.push_back(p);
    #9 rst_n = 1'b1;

    ph = "R1";
    for (int a = 0; a < 32; a++) step(1, 0, a, 31 - a, 0, 0, 0);
    step(1, 1, 1, 2, 3, 0, 0);            // first allocation: 32
    ph = "R2";
    step(1, 0, 0, 0, 0, 0, 0);
    ph = "R3";
    step(1, 1, 3, 3, 3, 0, 0);            // own sources see old mapping
    ph = "R4";
    step(1, 1, 3, 4, 3, 0, 0);
    ph = "R5";
    step(1, 1, 5, 6, 0, 0, 0);
    step(1, 0, 7, 8, 9, 0, 0);
    step(1, 1, 9, 9, 9, 0, 0);
    ph = "R6";
    for (int k = 0; k < 40; k++) step(1, 1, k % 32, (k + 5) % 32, (k % 31) + 1, 0, 0);
    step(1, 0, 4, 5, 6, 0, 0);
    ph = "R7";
    for (int k = 0; k < 4; k++) step(0, 0, 0, 0, 0, 1, 0);
    ph = "R8";
    for (int k = 0; k < 6; k++) step(1, 1, k + 1, k + 2, k + 10, 1, 0);
    ph = "R10";
    for (int k = 0; k < 4; k++) step(1, 1, 0, 1, 20, 0, 0);
    ph = "R9";
    step(1, 1, 1, 2, 3, 1, 1);            // flush together with a commit
    for (int a = 0; a < 32; a++) step(1, 0, a, a, 0, 0, 0);
    for (int k = 0; k < 6; k++) step(1, 1, 2, 3, k + 1, 0, 0);

    ph = "random";
    for (int k = 0; k < 4000; k++) begin
      int r;
      r = int'($urandom_range(0, 99));
      step(r < 85, r < 60, int'($urandom_range(0, 31)), int'($urandom_range(0, 31)),
           int'($urandom_range(0, 31)), $urandom_range(0, 99) < 45, r == 99);
    end
    @(negedge clk);
    finish_run();
  end

  initial begin
    #800000;
    errors++;
    checks++;
    $display("FAIL watchdog [%s] act=%0d exp=%0d", ph, cycles, 0);
    finish_run();
  end
endmodule